// File: doc/BRIEF.md
# Banked Memory Address Decoder

This block forms one larger memory out of four identical RAM banks kept as internal arrays. An incoming word address is split in two. The two most significant bits pass through an enabled 2-to-4 decoder to produce a one-hot bank select. The remaining low bits go to every bank in parallel as the word offset. As a result, each bank answers for one contiguous quarter of the address space: bank 0 for the lowest quarter, then bank 1, bank 2 and bank 3 in ascending order.

The memory enable gates the decoder. When it is low, no bank is selected and nothing is written. The read/write control is wired to all banks in parallel, and only the selected bank acts on it. A width option builds each bank from two byte lanes that share the address and the select. This gives a 16-bit word, with one lane holding bits 15:8 and the other holding bits 7:0.

Bank depth is set by a parameter. The default is kept small, and a setting of 16 gives 64K words per bank with an 18-bit address. Reads are registered. The word appears on the output one clock after the read is presented, and the output is zero after any cycle that is not an enabled read.

Top module: `banked_mem`

## Requirements
- R1: The bank index is the top two address bits and the offset is the low BANK_AW bits. Bank b serves addresses b*2^BANK_AW through (b+1)*2^BANK_AW-1.
- R2: While mem_en is 1, bank_sel has exactly one bit set, and that bit is bit b where b is the bank index. The value is combinational from the current inputs.
- R3: While mem_en is 0, bank_sel is all zeros.
- R4: At a rising edge with mem_en=1 and wr_en=1, wdata is stored at the offset in the selected bank only. The same offset in every other bank keeps its value.
- R5: At a rising edge with mem_en=1 and wr_en=0, the stored word is captured and shown on rdata until the next rising edge. This holds even when the same address was written at the preceding edge.
- R6: After a rising edge where mem_en=0 or wr_en=1, rdata is zero.
- R7: A write request with mem_en=0 has no effect on any stored word.
- R8: With WIDE=1, words are 16 bits. The upper byte lane holds bits 15:8 and the lower byte lane holds bits 7:0, and both are written and read together.
- R9: While rst_n is 0, rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the read register |
| mem_en | input | 1 | Memory enable; gates the bank decoder |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | BANK_AW+2 | Word address: bank index on top, offset below |
| wdata | input | 8 or 16 | Write data (16 when WIDE=1) |
| rdata | output | 8 or 16 | Registered read data |
| bank_sel | output | 4 | One-hot bank select decoded from addr |

## Verification
bank_sel is combinational, so it is checked one time unit after the driver changes the inputs, inside the same cycle. Read data is due one cycle after an operation is presented: the driver pushes the expected word at the falling edge where it drives the operation. The monitor pops that word at the next rising edge and compares it just after the edge. Every driven cycle pushes an item, including writes and idle cycles, which expect zero. The queue therefore stays aligned one-for-one with the register stage. Aliasing is exposed by writing distinct values at the first and last offset of every bank before any of them is read back.

// File: rtl/banked_mem_pkg.sv
package banked_mem_pkg;
    localparam int BANK_IDX_W = 2;
    localparam int NUM_BANKS  = 1 << BANK_IDX_W;
    localparam int LANE_W     = 8;
endpackage

// File: rtl/bank_decoder.sv
module bank_decoder #(
    parameter int IDX_W = 2,
    localparam int OUT_N = 1 << IDX_W
) (
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    output logic [OUT_N-1:0] sel
);
    always_comb begin
        sel = '0;
        if (en) begin
            sel[idx] = 1'b1;
        end
    end
endmodule

// File: rtl/byte_lane_ram.sv
module byte_lane_ram #(
    parameter int AW = 8,
    parameter int W  = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/banked_mem.sv
module banked_mem
    import banked_mem_pkg::*;
#(
    parameter int BANK_AW = 8,
    parameter bit WIDE    = 1'b0,
    localparam int AW     = BANK_AW + BANK_IDX_W,
    localparam int LANES  = WIDE ? 2 : 1,
    localparam int DW     = LANES * LANE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mem_en,
    input  logic                 wr_en,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    output logic [NUM_BANKS-1:0] bank_sel
);
    typedef struct packed {
        logic [DW-1:0] rdata;
    } state_t;

    state_t state_d, state_q;

    logic [BANK_IDX_W-1:0]           bank_idx;
    logic [BANK_AW-1:0]              offset;
    logic [NUM_BANKS-1:0][DW-1:0]    bank_rd;

    assign bank_idx = addr[AW-1 -: BANK_IDX_W];
    assign offset   = addr[BANK_AW-1:0];

    bank_decoder #(.IDX_W(BANK_IDX_W)) u_dec (
        .en  (mem_en),
        .idx (bank_idx),
        .sel (bank_sel)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            byte_lane_ram #(.AW(BANK_AW), .W(LANE_W)) u_lane (
                .clk   (clk),
                .we    (bank_sel[b] & wr_en),
                .addr  (offset),
                .wdata (wdata[l*LANE_W +: LANE_W]),
                .rdata (bank_rd[b][l*LANE_W +: LANE_W])
            );
        end
    end

    always_comb begin
        state_d = '0;
        if (!wr_en) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bank_sel[b]) begin
                    state_d.rdata = bank_rd[b];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata = state_q.rdata;

    // R2
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> ($countones(bank_sel) == 1 && bank_sel[bank_idx]));

    // R3
    sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_en |-> (bank_sel == '0));

    // R6
    rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_en || wr_en) |=> (rdata == '0));

    // R5
    rd_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && wr_en) ##1 (mem_en && !wr_en && addr == $past(addr))
        |=> (rdata == $past(wdata, 2)));

    // R9
    always_comb begin
        if (!rst_n) begin
            rst_clear_chk: assert (rdata == '0);
        end
    end
endmodule

// File: tb/banked_mem_tb.sv
module banked_mem_tb;
    localparam int BAW = 8;
    localparam int AW  = BAW + 2;
    localparam int BD  = 1 << BAW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mem_en = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]  wd_n = '0;
    logic [15:0] wd_w = '0;
    logic [7:0]  rd_n;
    logic [15:0] rd_w;
    logic [3:0]  sel_n, sel_w;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0]  exp_n;
        logic [15:0] exp_w;
        string       tag;
    } item_t;

    item_t sb_q[$];
    logic [7:0]  mdl_n [int];
    logic [15:0] mdl_w [int];

    always #5 clk = ~clk;

    banked_mem #(.BANK_AW(BAW), .WIDE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .wr_en(wr_en),
        .addr(addr), .wdata(wd_n), .rdata(rd_n), .bank_sel(sel_n)
    );

    banked_mem #(.BANK_AW(BAW), .WIDE(1'b1)) u_dut_w (
        .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .wr_en(wr_en),
        .addr(addr), .wdata(wd_w), .rdata(rd_w), .bank_sel(sel_w)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic op(input bit en, input bit wr, input logic [AW-1:0] a,
                      input logic [7:0] dn, input logic [15:0] dw, input string tag);
        item_t it;
        logic [3:0] esel;
        @(negedge clk);
        mem_en = en; wr_en = wr; addr = a; wd_n = dn; wd_w = dw;
        it.exp_n = '0;
        it.exp_w = '0;
        it.tag   = tag;
        if (en && !wr) begin
            it.exp_n = mdl_n[int'(a)];
            it.exp_w = mdl_w[int'(a)];
        end
        sb_q.push_back(it);
        if (en && wr) begin
            mdl_n[int'(a)] = dn;
            mdl_w[int'(a)] = dw;
        end
        esel = en ? (4'b0001 << a[AW-1 -: 2]) : 4'b0000;
        #1;
        chk(sel_n == esel, en ? "R2 bank_sel narrow" : "R3 bank_sel narrow", {12'b0, sel_n}, {12'b0, esel});
        chk(sel_w == esel, en ? "R2 bank_sel wide" : "R3 bank_sel wide", {12'b0, sel_w}, {12'b0, esel});
    endtask

    // monitor: pops the item queued for the edge just taken
    always @(posedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            #1;
            chk(rd_n == it.exp_n, {it.tag, " narrow"}, {8'b0, rd_n}, {8'b0, it.exp_n});
            chk(rd_w == it.exp_w, {"R8 ", it.tag, " wide"}, rd_w, it.exp_w);
        end
    end

    initial begin
        #1500000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(rd_n == '0, "R9 reset narrow", {8'b0, rd_n}, 16'h0);
        chk(rd_w == '0, "R9 reset wide", rd_w, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R4: distinct values at first and last offset of every bank
        for (int b = 0; b < 4; b++) begin
            op(1, 1, AW'(b*BD), 8'h10 + 8'(b), 16'hA100 + 16'(b*16'h0101), "R6 write idle");
            op(1, 1, AW'(b*BD + BD - 1), 8'h80 + 8'(b), 16'h5A00 + 16'(b*16'h0203), "R6 write idle");
        end
        for (int b = 0; b < 4; b++) begin
            op(1, 0, AW'(b*BD), 8'h0, 16'h0, "R1 R4 bank first word");
            op(1, 0, AW'(b*BD + BD - 1), 8'h0, 16'h0, "R1 R4 bank last word");
        end

        // R7: disabled write leaves bank 2 intact
        op(0, 1, AW'(2*BD), 8'hFF, 16'hFFFF, "R7 disabled write idle");
        op(1, 0, AW'(2*BD), 8'h0, 16'h0, "R7 word after disabled write");

        // R5: read right after write to same address, middle of bank 3
        op(1, 1, AW'(3*BD + 37), 8'hC3, 16'h3CC3, "R6 write idle");
        op(1, 0, AW'(3*BD + 37), 8'h0, 16'h0, "R5 read after write");
        op(1, 0, AW'(3*BD + 37), 8'h0, 16'h0, "R5 repeat read");

        // R4: overwrite bank 1 offset 0, neighbours unchanged
        op(1, 1, AW'(BD), 8'h6E, 16'hE66E, "R6 write idle");
        op(1, 0, AW'(0), 8'h0, 16'h0, "R4 bank0 unchanged");
        op(1, 0, AW'(2*BD), 8'h0, 16'h0, "R4 bank2 unchanged");
        op(1, 0, AW'(BD), 8'h0, 16'h0, "R4 bank1 new value");

        // R8: wide lanes hold separate bytes
        op(1, 1, AW'(BD + 9), 8'h01, 16'hF00F, "R6 write idle");
        op(1, 0, AW'(BD + 9), 8'h0, 16'h0, "R8 lane split");

        op(0, 0, AW'(0), 8'h0, 16'h0, "R6 idle");
        op(0, 0, AW'(3*BD), 8'h0, 16'h0, "R6 idle");
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule